// File: doc/BRIEF.md
# Word Left-Shift Execution Unit

This unit executes the 32-bit logical left-shift instruction of a 64-bit RISC core whose instruction bits are numbered big-endian (bit 0 is the most significant). It is given an instruction word and the values of two source registers. It decodes the word to confirm the opcode pair, shifts the low word of the value source left by a six-bit count, and returns a 64-bit result whose upper word is always zero. When the record flag is set, it also produces a four-bit condition field.

Each issue is marked with a valid strobe, and the results come out one clock later from registers. A word that is not this instruction is flagged as not accepted. In that case the unit raises neither the result strobe nor the condition write. The carry and overflow write enables are outputs that never assert.

Top module: `slw_exec_unit`

## Requirements
- R1: The word is accepted only when its bits 0-5 (vector bits [31:26]) equal 31 and its bits 21-30 (vector bits [10:1]) equal 24. An accepted issue raises `res_vld` and leaves `not_mine` low. A rejected issue raises `not_mine`, and `res_vld` and `cr_we` stay low.
- R2: The destination index `rd_idx` is taken from bits 11-15 (vector bits [20:16]). The value source comes from bits 6-10 and the count source from bits 16-20; the unit only reports these two as fields.
- R3: The count is `src_b[5:0]`. All higher bits of `src_b` have no effect on the result.
- R4: For a count n below 32, result[31:0] equals (src_a[31:0] << n) truncated to 32 bits. The upper 32 bits of `src_a` have no effect.
- R5: For a count from 32 to 63, the result is zero.
- R6: result[63:32] is always zero.
- R7: When bit 31 (vector bit [0]) is 1 on an accepted issue, `cr_we` is 1 and `cr_field` = {LT,GT,EQ,SO}. LT, GT and EQ come from a signed compare of result[31:0] against zero, and SO copies `so_in`. When the bit is 0, `cr_we` is 0.
- R8: Exactly one of LT, GT and EQ is set in `cr_field` whenever `cr_we` is 1. Bit 31 of the result set (for example 0x80000000) gives LT.
- R9: `ca_we` and `ov_we` are always 0.
- R10: All outputs are registered and appear exactly one clock after `issue_vld`. If `issue_vld` is low, the next cycle has `res_vld`, `cr_we` and `not_mine` low. A synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Instruction issue strobe |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | Value register contents |
| src_b | input | 64 | Count register contents |
| so_in | input | 1 | Summary-overflow flag |
| res_vld | output | 1 | Result valid |
| rd_idx | output | 5 | Destination register index |
| result | output | 64 | Destination value |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | {LT,GT,EQ,SO} |
| not_mine | output | 1 | Issued word is not this instruction |
| ca_we | output | 1 | Carry write enable (never set) |
| ov_we | output | 1 | Overflow write enable (never set) |

## Verification
Every output of this unit is due exactly one rising edge after the issue that produced it. The bench drives the inputs on the falling edge and samples on the next falling edge, so the sample falls inside the cycle that follows the registering edge. An idle cycle is inserted after some issues, and the bench then checks that the strobes fall on the following sample. The count is swept over all 64 values against several value patterns, including junk placed in the ignored high bits.

// File: rtl/slw_pkg.sv
package slw_pkg;
  localparam int XLEN   = 64;
  localparam int WLEN   = 32;
  localparam int CNTW   = 6;
  localparam int PRIMOP = 31;
  localparam int EXTOP  = 24;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

  function automatic logic [WLEN-1:0] shl_word(input logic [WLEN-1:0] v,
                                              input logic [CNTW-1:0] n);
    if (n[CNTW-1]) return '0;
    return v << n[CNTW-2:0];
  endfunction

  function automatic crf_t cmp_zero(input logic [WLEN-1:0] w, input logic so);
    crf_t c;
    c.lt = w[WLEN-1];
    c.eq = (w == '0);
    c.gt = !c.lt && !c.eq;
    c.so = so;
    return c;
  endfunction
endpackage

// File: rtl/slw_decode.sv
module slw_decode
  import slw_pkg::*;
(
  input  logic [31:0] instr,
  output logic        hit,
  output logic        rc,
  output logic [4:0]  ra_idx,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rb_idx
);
  logic [5:0] primop;
  logic [9:0] extop;
  assign primop = instr[31:26];
  assign extop  = instr[10:1];
  assign hit    = (primop == 6'(PRIMOP)) && (extop == 10'(EXTOP));
  assign rc     = instr[0];
  assign rs_idx = instr[25:21];
  assign ra_idx = instr[20:16];
  assign rb_idx = instr[15:11];
endmodule

// File: rtl/slw_datapath.sv
module slw_datapath
  import slw_pkg::*;
(
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            so_in,
  output logic [XLEN-1:0] res,
  output crf_t            crf
);
  logic [CNTW-1:0] cnt;
  logic [WLEN-1:0] low;
  assign cnt = src_b[CNTW-1:0];
  assign low = shl_word(src_a[WLEN-1:0], cnt);
  assign res = {{(XLEN-WLEN){1'b0}}, low};
  assign crf = cmp_zero(low, so_in);
endmodule

// File: rtl/slw_exec_unit.sv
module slw_exec_unit
  import slw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        issue_vld,
  input  logic [31:0] instr,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic        so_in,
  output logic        res_vld,
  output logic [4:0]  rd_idx,
  output logic [63:0] result,
  output logic        cr_we,
  output logic [3:0]  cr_field,
  output logic        not_mine,
  output logic        ca_we,
  output logic        ov_we
);
  logic       dec_hit, dec_rc;
  logic [4:0] dec_ra, dec_rs, dec_rb;
  logic [XLEN-1:0] dp_res;
  crf_t       dp_crf;
  logic       take, reject;

  slw_decode u_dec (
    .instr(instr), .hit(dec_hit), .rc(dec_rc),
    .ra_idx(dec_ra), .rs_idx(dec_rs), .rb_idx(dec_rb)
  );

  slw_datapath u_dp (
    .src_a(src_a), .src_b(src_b), .so_in(so_in),
    .res(dp_res), .crf(dp_crf)
  );

  assign take   = issue_vld && dec_hit;
  assign reject = issue_vld && !dec_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      rd_idx   <= '0;
      result   <= '0;
      cr_we    <= 1'b0;
      cr_field <= '0;
      not_mine <= 1'b0;
    end else begin
      res_vld  <= take;
      cr_we    <= take && dec_rc;
      not_mine <= reject;
      if (take) begin
        rd_idx   <= dec_ra;
        result   <= dp_res;
        cr_field <= dp_crf;
      end
    end
  end

  assign ca_we = 1'b0;
  assign ov_we = 1'b0;

  logic unused_ok;
  assign unused_ok = ^{dec_rs, dec_rb};
endmodule

// File: rtl/slw_exec_unit_chk.sv
module slw_exec_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        issue_vld,
  input logic [31:0] instr,
  input logic [63:0] src_b,
  input logic        res_vld,
  input logic [63:0] result,
  input logic        cr_we,
  input logic [3:0]  cr_field,
  input logic        not_mine,
  input logic        ca_we,
  input logic        ov_we
);
  logic started;
  always_ff @(posedge clk) started <= !rst;

  a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_vld && not_mine));
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    not_mine |-> !cr_we);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    result[63:32] == 32'h0);
  a_r5_big_count_zero: assert property (@(posedge clk) disable iff (rst || !started)
    (issue_vld && instr[31:26] == 6'd31 && instr[10:1] == 10'd24 && src_b[5])
      |=> (result == 64'h0));
  a_r8_onehot_cmp: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> $countones(cr_field[3:1]) == 1);
  a_r7_cr_needs_result: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> res_vld);
  a_r9_no_ca_ov: assert property (@(posedge clk) disable iff (rst)
    !ca_we && !ov_we);
  a_r10_idle: assert property (@(posedge clk) disable iff (rst || !started)
    !issue_vld |=> !res_vld && !not_mine && !cr_we);
endmodule

bind slw_exec_unit slw_exec_unit_chk u_chk (
  .clk(clk), .rst(rst), .issue_vld(issue_vld), .instr(instr), .src_b(src_b),
  .res_vld(res_vld), .result(result), .cr_we(cr_we), .cr_field(cr_field),
  .not_mine(not_mine), .ca_we(ca_we), .ov_we(ov_we)
);

// File: tb/slw_exec_unit_tb.sv
`timescale 1ns/1ps
module slw_exec_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_vld = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic so_in = 1'b0;
  logic res_vld, cr_we, not_mine, ca_we, ov_we;
  logic [4:0] rd_idx;
  logic [63:0] result;
  logic [3:0] cr_field;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slw_exec_unit dut_i (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .instr(instr),
    .src_a(src_a), .src_b(src_b), .so_in(so_in),
    .res_vld(res_vld), .rd_idx(rd_idx), .result(result), .cr_we(cr_we),
    .cr_field(cr_field), .not_mine(not_mine), .ca_we(ca_we), .ov_we(ov_we)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] ra,
                                      input logic [4:0] rb, input logic rc);
    return {6'd31, rs, ra, rb, 10'd24, rc};
  endfunction

  // expected value computed by repeated doubling
  function automatic logic [63:0] ref_shift(input logic [63:0] a, input logic [63:0] b);
    longint unsigned v = a & 64'hFFFF_FFFF;
    int n = int'(b % 64);
    if (n >= 32) return 64'h0;
    for (int i = 0; i < n; i++) v = (v * 2) % 64'h1_0000_0000;
    return v;
  endfunction

  function automatic logic [3:0] ref_cr(input logic [63:0] r, input logic so);
    int signed s = int'(r[31:0]);
    if (s < 0) return {3'b100, so};
    if (s > 0) return {3'b010, so};
    return {3'b001, so};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic so);
    @(negedge clk);
    issue_vld = 1'b1; instr = w; src_a = a; src_b = b; so_in = so;
    @(negedge clk);
    issue_vld = 1'b0;
  endtask

  task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                         input logic rc, input logic so, input logic [4:0] ra);
    logic [63:0] e;
    e = ref_shift(a, b);
    issue(mk(5'd3, ra, 5'd7, rc), a, b, so);
    chk("R1 res_vld", 64'(res_vld), 64'd1);
    chk("R1 not_mine", 64'(not_mine), 64'd0);
    chk("R2 rd_idx", 64'(rd_idx), 64'(ra));
    if (b[5]) chk("R5 big count", result, 64'h0);
    else      chk("R3 R4 shift", result, e);
    chk("R6 upper", 64'(result[63:32]), 64'h0);
    chk("R7 cr_we", 64'(cr_we), 64'(rc));
    if (rc) begin
      chk("R7 cr_field", 64'(cr_field), 64'(ref_cr(e, so)));
      chk("R8 onehot", 64'($countones(cr_field[3:1])), 64'd1);
    end
    chk("R9 ca ov", 64'({ca_we, ov_we}), 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [6];
    pats[0] = 64'h0000_0000_0000_0001;
    pats[1] = 64'hDEAD_BEEF_8000_0001;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h1234_5678_9ABC_DEF0;
    pats[4] = 64'h0;
    pats[5] = 64'hFFFF_0000_4000_0000;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset res_vld", 64'(res_vld), 64'd0);
    chk("R10 reset result", result, 64'd0);
    chk("R10 reset cr", 64'({cr_we, cr_field, not_mine}), 64'd0);
    rst = 1'b0;
    for (int p = 0; p < 6; p++)
      for (int n = 0; n < 64; n++)
        // junk in high RB bits checks R3
        run_one(pats[p], {32'hA5A5_0000 | 32'(p), 26'h3F_FFC0 >> 6, 6'(n)} , 1'(n % 2), 1'(n % 3 == 0), 5'(n % 32));
    // R8: 0x80000000 is negative
    run_one(64'h1, 64'd31, 1'b1, 1'b0, 5'd9);
    chk("R8 lt for 0x80000000", 64'(cr_field), 64'h8);
    // R3 explicit: bit 6 set means count 0, not 64
    run_one(64'h5, 64'h40, 1'b1, 1'b1, 5'd1);
    chk("R3 high bit ignored", result, 64'h5);
    // R10 idle gap after issue
    @(negedge clk);
    chk("R10 idle res_vld", 64'({res_vld, cr_we, not_mine}), 64'd0);
    // R1 rejects
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = mk(5'd1, 5'd2, 5'd3, 1'b1);
      if (k == 0) w[31:26] = 6'd30;
      if (k == 1) w[10:1]  = 10'd536;
      if (k == 2) w[10:1]  = 10'd25;
      if (k == 3) w[31:26] = 6'd63;
      issue(w, 64'h1, 64'h1, 1'b1);
      chk("R1 reject not_mine", 64'(not_mine), 64'd1);
      chk("R1 reject res_vld", 64'(res_vld), 64'd0);
      chk("R1 reject cr_we", 64'(cr_we), 64'd0);
    end
    // R10 reset mid-run
    issue(mk(5'd0, 5'd4, 5'd0, 1'b1), 64'h3, 64'h1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 sync reset", 64'({res_vld, cr_we, cr_field, rd_idx}), 64'd0);
    chk("R10 sync reset result", result, 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule